// File: doc/BRIEF.md
# Data Load Path Controller

This block sequences a single data load for a processor core that has a memory management unit. A load request carries a virtual address, an access size (byte, halfword or word), an MMU enable, an alignment-check enable, a data-cache enable and an endianness bit. The controller runs the request through a fixed series of stages. It checks alignment, then obtains a physical address with cacheable and bufferable attributes from a translator. It then probes a read buffer, a main cache and a mini cache, in that order. On a miss it either issues a cache soft-flush for a reserved physical window, or drains the write buffer and then either fills a cache line or reads memory uncached. It finishes by returning the requested byte lanes.

Every neighbouring unit sits behind a simple request/acknowledge port: the translator, the probe port shared by the three lookup structures, the soft-flush port, the write-buffer drain, the line fill and the memory read. A request is held until its acknowledge, and the response fields are sampled on the acknowledge edge. At most one neighbour port is active at any time. Each accepted load produces exactly one single-cycle response that carries a fault code and a data word.

Top module: `dload_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and no neighbour request (`xl_req`, `probe_req`, `flush_req`, `drain_req`, `fill_req`, `mem_req`) is asserted.
- R2: With `mmu_en`=0 the load goes straight to memory with `mem_addr` equal to the request address and `mem_size` equal to the request size. No translation, alignment check or probe takes place, and the memory word is returned unchanged with fault code 0.
- R3: Size is encoded 0 byte, 1 halfword, 2 word. With `align_en`=1, a word access with address bits [1:0] nonzero, or a halfword access with bit 0 set, responds with fault code 1 and data 0 and touches no neighbour port. With `align_en`=0 the access proceeds using the word-aligned address.
- R4: A nonzero `xl_fault` from the translator ends the load with that code and data 0, and no later port is touched.
- R5: After a clean translation the probe port is used with target 0 (read buffer), then 1 (main cache), then 2 (mini cache). It stops at the first hit, so the structures after a hit are never probed.
- R6: A read-buffer hit with a nonzero `probe_fault` responds with that fault code and data 0.
- R7: On a miss with a physical address in [0xE0000000, 0xE8000000), no memory read, drain or fill occurs and the response carries data 0 and fault 0. If the page is cacheable, one soft-flush is issued with `flush_to_main`=1 when bufferable and 0 otherwise. If the page is not cacheable, no soft-flush is issued.
- R8: On a miss outside the window with the page bufferable, a write-buffer drain completes before the fill or memory read is issued. Without bufferable no drain occurs.
- R9: On a miss outside the window with the page cacheable and `dcache_en`=1, one fill is issued with `fill_to_main`=1 when bufferable and 0 otherwise. The response data is the lane extraction of the fill word.
- R10: Otherwise one uncached memory read is issued at the physical word address with the low bits set as follows: the address bits [1:0] for a byte, {bit1,0} for a halfword, and 00 for a word. The memory word is returned unchanged.
- R11: Data from a probe hit or a fill is lane-extracted and zero-extended. The halfword shift is ((big×2) XOR (addr bit1 ×2))×8 bits. The byte shift is ((big×3) XOR addr[1:0])×8 bits. A word is returned whole.
- R12: Each accepted request yields exactly one single-cycle `rsp_valid` pulse. `req_ready` is 0 from acceptance until the response, and a `req_valid` asserted in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request strobe |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_addr | input | AW | Virtual address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| mmu_en | input | 1 | Translation enable |
| align_en | input | 1 | Alignment check enable |
| dcache_en | input | 1 | Data cache enable |
| big_end | input | 1 | Big-endian lane order |
| xl_req | output | 1 | Translation request |
| xl_va | output | AW | Word-aligned virtual address to translate |
| xl_ack | input | 1 | Translation done |
| xl_fault | input | 4 | Translation/permission fault code, 0 for none |
| xl_pa | input | AW | Physical word address |
| xl_cacheable | input | 1 | Page cacheable |
| xl_bufferable | input | 1 | Page bufferable |
| probe_req | output | 1 | Lookup request |
| probe_tgt | output | 2 | 0 read buffer, 1 main cache, 2 mini cache |
| probe_va | output | AW | Word-aligned lookup address |
| probe_ack | input | 1 | Lookup done |
| probe_hit | input | 1 | Lookup hit |
| probe_fault | input | 4 | Stored fault of a read-buffer hit |
| probe_data | input | 32 | Hit word |
| flush_req | output | 1 | Soft-flush request |
| flush_to_main | output | 1 | 1 main cache, 0 mini cache |
| flush_pa | output | AW | Physical address for the flush |
| flush_ack | input | 1 | Soft-flush done |
| drain_req | output | 1 | Write-buffer drain request |
| drain_ack | input | 1 | Drain complete |
| fill_req | output | 1 | Line allocate request |
| fill_to_main | output | 1 | 1 main cache, 0 mini cache |
| fill_va | output | AW | Word-aligned virtual address |
| fill_pa | output | AW | Word-aligned physical address |
| fill_ack | input | 1 | Fill done |
| fill_data | input | 32 | Requested word of the filled line |
| mem_req | output | 1 | Uncached memory read request |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Memory access size |
| mem_ack | input | 1 | Memory read done |
| mem_data | input | 32 | Memory read data |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_fault | output | 4 | Fault code, 0 for success |
| rsp_data | output | 32 | Load data |

## Verification
The bench goes after the ordering corners. A read-buffer hit must stop probing; a controller that kept probing would show extra probe targets in the logged sequence. A bufferable miss must drain before its read; a design that read first would log the drain after the fill or memory event. A window hit on a non-cacheable page must still suppress the read; a design that missed this would issue a memory read or return memory data instead of zero. Misaligned accesses with the check disabled, big-endian lane selection and a request raised while busy are also covered. A wrong lane shift would return the wrong byte, a missed alignment exemption would return fault 1, and a design that took the busy request would give a second response.

// File: rtl/dload_pkg.sv
package dload_pkg;
    localparam int DATA_W = 32;
    localparam int FLT_W  = 4;

    localparam logic [FLT_W-1:0] FLT_NONE  = 4'd0;
    localparam logic [FLT_W-1:0] FLT_ALIGN = 4'd1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        TGT_RB   = 2'd0,
        TGT_MAIN = 2'd1,
        TGT_MINI = 2'd2
    } tgt_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_XLATE,
        S_PROBE,
        S_FLUSH,
        S_DRAIN,
        S_FILL,
        S_MEM,
        S_RESP
    } state_e;
endpackage

// File: rtl/dload_align.sv
module dload_align
    import dload_pkg::*;
(
    input  logic       chk_en,
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       misaligned
);
    always_comb begin
        misaligned = 1'b0;
        if (chk_en) begin
            if (size == SZ_HALF)
                misaligned = addr_lo[0];
            else if (size == SZ_WORD)
                misaligned = |addr_lo;
        end
    end
endmodule

// File: rtl/dload_lane.sv
module dload_lane
    import dload_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        size,
    input  logic [1:0]        addr_lo,
    input  logic              big,
    output logic [DATA_W-1:0] data
);
    logic [1:0]        lane;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        if (size == SZ_HALF)
            lane = {big, 1'b0} ^ {addr_lo[1], 1'b0};
        else
            lane = {big, big} ^ addr_lo;
        shifted = word >> {lane, 3'b000};
        case (size)
            SZ_BYTE: data = {24'd0, shifted[7:0]};
            SZ_HALF: data = {16'd0, shifted[15:0]};
            default: data = word;
        endcase
    end

    // R11: narrow results are zero-extended
    always_comb begin
        if (size == SZ_BYTE)
            a_r11_byte_zext: assert (data[31:8] == 24'd0);
        if (size == SZ_HALF)
            a_r11_half_zext: assert (data[31:16] == 16'd0);
    end
endmodule

// File: rtl/dload_ctrl.sv
module dload_ctrl
    import dload_pkg::*;
#(
    parameter int               AW     = 32,
    parameter logic [AW-1:0]    WIN_LO = 32'hE000_0000,
    parameter logic [AW-1:0]    WIN_HI = 32'hE800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              mmu_en,
    input  logic              align_en,
    input  logic              dcache_en,
    input  logic              big_end,
    output logic              xl_req,
    output logic [AW-1:0]     xl_va,
    input  logic              xl_ack,
    input  logic [FLT_W-1:0]  xl_fault,
    input  logic [AW-1:0]     xl_pa,
    input  logic              xl_cacheable,
    input  logic              xl_bufferable,
    output logic              probe_req,
    output logic [1:0]        probe_tgt,
    output logic [AW-1:0]     probe_va,
    input  logic              probe_ack,
    input  logic              probe_hit,
    input  logic [FLT_W-1:0]  probe_fault,
    input  logic [DATA_W-1:0] probe_data,
    output logic              flush_req,
    output logic              flush_to_main,
    output logic [AW-1:0]     flush_pa,
    input  logic              flush_ack,
    output logic              drain_req,
    input  logic              drain_ack,
    output logic              fill_req,
    output logic              fill_to_main,
    output logic [AW-1:0]     fill_va,
    output logic [AW-1:0]     fill_pa,
    input  logic              fill_ack,
    input  logic [DATA_W-1:0] fill_data,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    output logic              rsp_valid,
    output logic [FLT_W-1:0]  rsp_fault,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int HI = AW - 2;

    typedef struct packed {
        state_e             st;
        logic [AW-1:0]      va;
        logic [1:0]         size;
        logic               big;
        logic               mmu;
        logic               dce;
        logic [AW-1:0]      pa;
        logic               c;
        logic               b;
        tgt_e               tgt;
        logic [FLT_W-1:0]   flt;
        logic [DATA_W-1:0]  data;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              req_misaligned;
    logic [DATA_W-1:0] lane_word;
    logic [DATA_W-1:0] lane_data;
    logic              in_window;
    logic [1:0]        mem_lo;

    dload_align u_align (
        .chk_en     (align_en),
        .size       (req_size),
        .addr_lo    (req_addr[1:0]),
        .misaligned (req_misaligned)
    );

    assign lane_word = (ctx_q.st == S_FILL) ? fill_data : probe_data;

    dload_lane u_lane (
        .word    (lane_word),
        .size    (ctx_q.size),
        .addr_lo (ctx_q.va[1:0]),
        .big     (ctx_q.big),
        .data    (lane_data)
    );

    assign in_window = (ctx_q.pa >= WIN_LO) && (ctx_q.pa < WIN_HI);

    always_comb begin
        case (ctx_q.size)
            SZ_BYTE: mem_lo = ctx_q.va[1:0];
            SZ_HALF: mem_lo = {ctx_q.va[1], 1'b0};
            default: mem_lo = 2'b00;
        endcase
    end

    // next-state process
    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    ctx_d.va   = req_addr;
                    ctx_d.size = req_size;
                    ctx_d.big  = big_end;
                    ctx_d.mmu  = mmu_en;
                    ctx_d.dce  = dcache_en;
                    ctx_d.flt  = FLT_NONE;
                    ctx_d.data = '0;
                    ctx_d.c    = 1'b0;
                    ctx_d.b    = 1'b0;
                    ctx_d.tgt  = TGT_RB;
                    if (!mmu_en)
                        ctx_d.st = S_MEM;
                    else if (req_misaligned) begin
                        ctx_d.flt = FLT_ALIGN;
                        ctx_d.st  = S_RESP;
                    end else
                        ctx_d.st = S_XLATE;
                end
            end
            S_XLATE: begin
                if (xl_ack) begin
                    if (xl_fault != FLT_NONE) begin
                        ctx_d.flt = xl_fault;
                        ctx_d.st  = S_RESP;
                    end else begin
                        ctx_d.pa  = xl_pa;
                        ctx_d.c   = xl_cacheable;
                        ctx_d.b   = xl_bufferable;
                        ctx_d.tgt = TGT_RB;
                        ctx_d.st  = S_PROBE;
                    end
                end
            end
            S_PROBE: begin
                if (probe_ack) begin
                    if (probe_hit) begin
                        if (ctx_q.tgt == TGT_RB && probe_fault != FLT_NONE)
                            ctx_d.flt = probe_fault;
                        else
                            ctx_d.data = lane_data;
                        ctx_d.st = S_RESP;
                    end else if (ctx_q.tgt != TGT_MINI) begin
                        ctx_d.tgt = tgt_e'(ctx_q.tgt + 2'd1);
                    end else if (in_window) begin
                        ctx_d.st = ctx_q.c ? S_FLUSH : S_RESP;
                    end else if (ctx_q.b) begin
                        ctx_d.st = S_DRAIN;
                    end else begin
                        ctx_d.st = (ctx_q.c && ctx_q.dce) ? S_FILL : S_MEM;
                    end
                end
            end
            S_FLUSH: begin
                if (flush_ack)
                    ctx_d.st = S_RESP;
            end
            S_DRAIN: begin
                if (drain_ack)
                    ctx_d.st = (ctx_q.c && ctx_q.dce) ? S_FILL : S_MEM;
            end
            S_FILL: begin
                if (fill_ack) begin
                    ctx_d.data = lane_data;
                    ctx_d.st   = S_RESP;
                end
            end
            S_MEM: begin
                if (mem_ack) begin
                    ctx_d.data = mem_data;
                    ctx_d.st   = S_RESP;
                end
            end
            S_RESP: begin
                ctx_d.st = S_IDLE;
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q     <= '0;
            ctx_q.st  <= S_IDLE;
            ctx_q.tgt <= TGT_RB;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // outputs
    assign req_ready     = (ctx_q.st == S_IDLE);
    assign xl_req        = (ctx_q.st == S_XLATE);
    assign xl_va         = {ctx_q.va[AW-1:2], 2'b00};
    assign probe_req     = (ctx_q.st == S_PROBE);
    assign probe_tgt     = ctx_q.tgt;
    assign probe_va      = {ctx_q.va[AW-1:2], 2'b00};
    assign flush_req     = (ctx_q.st == S_FLUSH);
    assign flush_to_main = ctx_q.b;
    assign flush_pa      = ctx_q.pa;
    assign drain_req     = (ctx_q.st == S_DRAIN);
    assign fill_req      = (ctx_q.st == S_FILL);
    assign fill_to_main  = ctx_q.b;
    assign fill_va       = {ctx_q.va[AW-1:2], 2'b00};
    assign fill_pa       = {ctx_q.pa[AW-1:2], 2'b00};
    assign mem_req       = (ctx_q.st == S_MEM);
    assign mem_addr      = ctx_q.mmu ? {ctx_q.pa[HI+1:2], mem_lo} : ctx_q.va;
    assign mem_size      = ctx_q.size;
    assign rsp_valid     = (ctx_q.st == S_RESP);
    assign rsp_fault     = ctx_q.flt;
    assign rsp_data      = ctx_q.data;

    // drain tracker used only by the ordering assertion
    logic drained_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            drained_q <= 1'b0;
        else if (rsp_valid)
            drained_q <= 1'b0;
        else if (drain_req && drain_ack)
            drained_q <= 1'b1;
    end

    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xl_req, probe_req, flush_req, drain_req, fill_req, mem_req}));

    a_r5_rb_then_main: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && probe_ack && !probe_hit && probe_tgt == TGT_RB)
        |=> (probe_req && probe_tgt == TGT_MAIN));

    a_r5_main_then_mini: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && probe_ack && !probe_hit && probe_tgt == TGT_MAIN)
        |=> (probe_req && probe_tgt == TGT_MINI));

    a_r6_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_data == '0));

    a_r8_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_req || mem_req) && ctx_q.mmu && ctx_q.b) |-> drained_q);

    a_r4_xl_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !xl_ack) |=> (xl_req && $stable(xl_va)));
endmodule

// File: tb/dload_ctrl_bench.sv
module dload_ctrl_bench;
    import dload_pkg::*;

    localparam int AW = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n;

    logic        req_valid, req_ready;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        mmu_en, align_en, dcache_en, big_end;
    logic        xl_req, xl_ack, xl_cacheable, xl_bufferable;
    logic [31:0] xl_va, xl_pa;
    logic [3:0]  xl_fault;
    logic        probe_req, probe_ack, probe_hit;
    logic [1:0]  probe_tgt;
    logic [31:0] probe_va, probe_data;
    logic [3:0]  probe_fault;
    logic        flush_req, flush_to_main, flush_ack;
    logic [31:0] flush_pa;
    logic        drain_req, drain_ack;
    logic        fill_req, fill_to_main, fill_ack;
    logic [31:0] fill_va, fill_pa, fill_data;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_data;
    logic [1:0]  mem_size;
    logic        rsp_valid;
    logic [3:0]  rsp_fault;
    logic [31:0] rsp_data;

    dload_ctrl u_dload_ctrl (.*);

    int checks = 0;
    int errors = 0;

    // scenario seen by the neighbour models
    logic [31:0] s_va, s_pa, s_rbw, s_mw, s_nw, s_fw, s_memw;
    logic [1:0]  s_size;
    logic        s_mmu, s_aln, s_dce, s_big, s_c, s_b;
    logic [3:0]  s_xflt, s_rbflt;
    logic        s_rbhit, s_mhit, s_nhit;

    // event log
    int          ev_n, n_xl, n_flush, n_drain, n_fill, n_mem, drain_at, read_at, rsp_cnt;
    logic [7:0]  probe_seq;
    logic        fill_main_l, flush_main_l;
    logic [31:0] maddr_l;
    logic [1:0]  msize_l;

    // expectations
    logic [3:0]  e_flt;
    logic [31:0] e_data, e_maddr;
    logic [7:0]  e_seq;
    logic        e_xl, e_flush, e_flmain, e_drain, e_fill, e_fillmain, e_mem;
    string       e_tag;

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // neighbour models, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            xl_ack = 0; probe_ack = 0; flush_ack = 0; drain_ack = 0;
            fill_ack = 0; mem_ack = 0;
        end else begin
            xl_fault = s_xflt; xl_pa = s_pa;
            xl_cacheable = s_c; xl_bufferable = s_b;
            case (probe_tgt)
                2'd0: begin probe_hit = s_rbhit; probe_data = s_rbw; probe_fault = s_rbflt; end
                2'd1: begin probe_hit = s_mhit;  probe_data = s_mw;  probe_fault = 4'd0; end
                default: begin probe_hit = s_nhit; probe_data = s_nw; probe_fault = 4'd0; end
            endcase
            fill_data = s_fw; mem_data = s_memw;
            xl_ack    = xl_req    && ($urandom_range(3) != 0);
            probe_ack = probe_req && ($urandom_range(3) != 0);
            flush_ack = flush_req && ($urandom_range(3) != 0);
            drain_ack = drain_req && ($urandom_range(3) != 0);
            fill_ack  = fill_req  && ($urandom_range(3) != 0);
            mem_ack   = mem_req   && ($urandom_range(3) != 0);
            if (xl_req && xl_ack) begin ev_n++; n_xl++; end
            if (probe_req && probe_ack) begin
                ev_n++; probe_seq = {probe_seq[5:0], probe_tgt + 2'd1};
            end
            if (flush_req && flush_ack) begin ev_n++; n_flush++; flush_main_l = flush_to_main; end
            if (drain_req && drain_ack) begin ev_n++; n_drain++; drain_at = ev_n; end
            if (fill_req && fill_ack) begin
                ev_n++; n_fill++; read_at = ev_n; fill_main_l = fill_to_main;
            end
            if (mem_req && mem_ack) begin
                ev_n++; n_mem++; read_at = ev_n; maddr_l = mem_addr; msize_l = mem_size;
            end
            if (rsp_valid) rsp_cnt++;
        end
    end

    function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] sz,
                                         input logic [1:0] a, input logic big);
        int idx;
        if (sz == 2'd0) begin
            idx = big ? 3 - int'(a) : int'(a);
            return {24'd0, w[idx*8 +: 8]};
        end else if (sz == 2'd1) begin
            idx = big ? (a[1] ? 0 : 1) : (a[1] ? 1 : 0);
            return {16'd0, w[idx*16 +: 16]};
        end
        return w;
    endfunction

    task automatic model();
        logic [1:0] lo;
        e_flt = 0; e_data = 0; e_seq = 0; e_xl = 0; e_flush = 0; e_flmain = 0;
        e_drain = 0; e_fill = 0; e_fillmain = 0; e_mem = 0; e_maddr = 0;
        if (!s_mmu) begin
            e_tag = "R2"; e_mem = 1; e_maddr = s_va; e_data = s_memw;
        end else if (s_aln && ((s_size == 2'd2 && s_va[1:0] != 0) ||
                               (s_size == 2'd1 && s_va[0]))) begin
            e_tag = "R3"; e_flt = 4'd1;
        end else begin
            e_xl = 1;
            if (s_xflt != 0) begin
                e_tag = "R4"; e_flt = s_xflt;
            end else if (s_rbhit) begin
                e_seq = 8'd1;
                if (s_rbflt != 0) begin e_tag = "R6"; e_flt = s_rbflt; end
                else begin e_tag = "R11"; e_data = pick(s_rbw, s_size, s_va[1:0], s_big); end
            end else if (s_mhit) begin
                e_seq = 8'd6; e_tag = "R11"; e_data = pick(s_mw, s_size, s_va[1:0], s_big);
            end else begin
                e_seq = 8'd27;
                if (s_nhit) begin
                    e_tag = "R11"; e_data = pick(s_nw, s_size, s_va[1:0], s_big);
                end else if (s_pa >= 32'hE000_0000 && s_pa < 32'hE800_0000) begin
                    e_tag = "R7"; e_flush = s_c; e_flmain = s_b;
                end else begin
                    e_drain = s_b;
                    if (s_c && s_dce) begin
                        e_tag = "R9"; e_fill = 1; e_fillmain = s_b;
                        e_data = pick(s_fw, s_size, s_va[1:0], s_big);
                    end else begin
                        e_tag = "R10"; e_mem = 1; e_data = s_memw;
                        lo = (s_size == 2'd0) ? s_va[1:0] :
                             (s_size == 2'd1) ? {s_va[1], 1'b0} : 2'b00;
                        e_maddr = {s_pa[31:2], lo};
                    end
                end
            end
        end
    endtask

    task automatic rand_scn();
        s_va = $urandom; s_size = 2'($urandom_range(2));
        s_mmu = ($urandom_range(7) != 0); s_aln = $urandom_range(1);
        s_dce = $urandom_range(1); s_big = $urandom_range(1);
        s_xflt = ($urandom_range(7) == 0) ? 4'($urandom_range(15, 2)) : 4'd0;
        s_pa = {$urandom, 2'b00} >> 0;
        s_pa[1:0] = 2'b00;
        if ($urandom_range(4) == 0) s_pa[31:27] = 5'b11100;
        s_c = $urandom_range(1); s_b = $urandom_range(1);
        s_rbhit = ($urandom_range(4) == 0);
        s_rbflt = $urandom_range(1) ? 4'($urandom_range(15, 2)) : 4'd0;
        s_mhit = ($urandom_range(3) == 0); s_nhit = ($urandom_range(3) == 0);
        s_rbw = $urandom; s_mw = $urandom; s_nw = $urandom; s_fw = $urandom; s_memw = $urandom;
    endtask

    task automatic do_req(input logic inject);
        int start_cnt;
        bit got;
        logic [3:0]  a_flt;
        logic [31:0] a_data;
        model();
        ev_n = 0; n_xl = 0; n_flush = 0; n_drain = 0; n_fill = 0; n_mem = 0;
        drain_at = 0; read_at = 0; probe_seq = 0; fill_main_l = 0; flush_main_l = 0;
        maddr_l = 0; msize_l = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        start_cnt = rsp_cnt;
        req_valid = 1; req_addr = s_va; req_size = s_size; mmu_en = s_mmu;
        align_en = s_aln; dcache_en = s_dce; big_end = s_big;
        got = 0; a_flt = 0; a_data = 0;
        for (int i = 0; i < 300 && !got; i++) begin
            @(negedge clk);
            if (rsp_valid) begin
                got = 1; a_flt = rsp_fault; a_data = rsp_data; req_valid = 0;
            end else if (inject && !req_ready) begin
                req_valid = 1; req_addr = ~s_va; mmu_en = 0; req_size = 2'd2;
            end else begin
                req_valid = 0;
            end
        end
        req_valid = 0;
        repeat (3) @(negedge clk);
        check("R12", "response seen", got, 1'b1);
        check("R12", "response count", rsp_cnt - start_cnt, 1);
        check(e_tag, "fault", a_flt, e_flt);
        check(e_tag, "data", a_data, e_data);
        check(e_xl ? "R4" : "R3", "translations", n_xl, e_xl);
        check("R5", "probe order", probe_seq, e_seq);
        check("R7", "flushes", n_flush, e_flush);
        if (e_flush) check("R7", "flush target", flush_main_l, e_flmain);
        check("R8", "drains", n_drain, e_drain);
        if (e_drain) check("R8", "drain before read", drain_at < read_at, 1'b1);
        check("R9", "fills", n_fill, e_fill);
        if (e_fill) check("R9", "fill target", fill_main_l, e_fillmain);
        check(e_tag == "R2" ? "R2" : "R10", "memory reads", n_mem, e_mem);
        if (e_mem) begin
            check(e_tag, "mem addr", maddr_l, e_maddr);
            check(e_tag, "mem size", msize_l, s_size);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; req_valid = 0; req_addr = 0; req_size = 0; mmu_en = 0;
        align_en = 0; dcache_en = 0; big_end = 0; rsp_cnt = 0;
        xl_fault = 0; xl_pa = 0; xl_cacheable = 0; xl_bufferable = 0;
        probe_hit = 0; probe_fault = 0; probe_data = 0; fill_data = 0; mem_data = 0;
        xl_ack = 0; probe_ack = 0; flush_ack = 0; drain_ack = 0; fill_ack = 0; mem_ack = 0;
        rand_scn();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "req_ready", req_ready, 1'b1);
        check("R1", "rsp_valid", rsp_valid, 1'b0);
        check("R1", "port requests",
              {xl_req, probe_req, flush_req, drain_req, fill_req, mem_req}, 6'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "idle after release", {req_ready, rsp_valid}, 2'b10);

        // R2 MMU off, byte at odd address
        rand_scn(); s_mmu = 0; s_size = 2'd0; s_va = 32'h1234_5673; do_req(0);
        // R3 misaligned word and halfword
        rand_scn(); s_mmu = 1; s_aln = 1; s_size = 2'd2; s_va = 32'h4000_0002; do_req(0);
        rand_scn(); s_mmu = 1; s_aln = 1; s_size = 2'd1; s_va = 32'h4000_0001; do_req(0);
        // R3/R10 misaligned word with checking off
        rand_scn(); s_mmu = 1; s_aln = 0; s_size = 2'd2; s_va = 32'h4000_0003;
        s_xflt = 0; s_rbhit = 0; s_mhit = 0; s_nhit = 0; s_pa = 32'h0010_0000; s_c = 0; s_b = 0;
        do_req(0);
        // R11 big-endian byte from main cache
        rand_scn(); s_mmu = 1; s_size = 2'd0; s_va = 32'h0000_0101; s_big = 1;
        s_xflt = 0; s_rbhit = 0; s_mhit = 1; s_mw = 32'hA1B2_C3D4; do_req(0);
        // R7 window, not cacheable then cacheable bufferable
        rand_scn(); s_mmu = 1; s_aln = 0; s_xflt = 0; s_rbhit = 0; s_mhit = 0; s_nhit = 0;
        s_pa = 32'hE400_0000; s_c = 0; do_req(0);
        rand_scn(); s_mmu = 1; s_aln = 0; s_xflt = 0; s_rbhit = 0; s_mhit = 0; s_nhit = 0;
        s_pa = 32'hE7FF_FFFC; s_c = 1; s_b = 1; do_req(0);
        // R6 read-buffer stored fault
        rand_scn(); s_mmu = 1; s_aln = 0; s_xflt = 0; s_rbhit = 1; s_rbflt = 4'd9; do_req(0);
        // R8/R9 bufferable fill into main
        rand_scn(); s_mmu = 1; s_aln = 0; s_xflt = 0; s_rbhit = 0; s_mhit = 0; s_nhit = 0;
        s_pa = 32'h0800_0000; s_c = 1; s_b = 1; s_dce = 1; s_size = 2'd1; do_req(0);
        // R12 request while busy is ignored
        rand_scn(); s_mmu = 1; s_aln = 0; s_xflt = 0; s_rbhit = 0; s_mhit = 0; s_nhit = 0;
        s_pa = 32'h0800_0040; s_b = 1; do_req(1);

        for (int n = 0; n < 600; n++) begin
            rand_scn();
            do_req(n % 17 == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule